// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block sequences an external dual-slope integrating converter through its four phases (auto-zero, integrate, de-integrate and integrator-zero) by driving a two-bit phase code. Every phase decision is taken on a system tick that fires once every `TICK_DIV` clocks. Auto-zero and integrate run for a programmable number of ticks set by an 8-bit load value. De-integrate runs until the converter's comparator falls, and integrator-zero runs until the comparator rises again.

The block counts the de-integrate ticks in a `CNT_W`-bit counter. That count, a polarity bit and an overrange bit go to an output holding register at the start of every auto-zero. An active-low valid flag is low for the whole of auto-zero, so a host can poll the flag or use it as an interrupt. An active-low enable input that is driven high overrides the sequence and parks the block in auto-zero. After reset the block waits in integrator-zero for the comparator to go high.

Top module: `dslope_sequencer`

## Requirements
- R1: The phase code {phase_a, phase_b} is 01 in auto-zero, 10 in integrate, 11 in de-integrate and 00 in integrator-zero. The normal order is auto-zero, integrate, de-integrate, integrator-zero, then auto-zero again.
- R2: The phase code changes only on a system tick, which fires once every `TICK_DIV` clocks (default 4).
- R3: Auto-zero and integrate each last (2^LV_W - load_val) x 2^(CNT_W-LV_W) ticks. With the defaults, a load value of 0xFF gives 256 ticks and 0x00 gives 65536 ticks. The load value is sampled when each of these phases is entered.
- R4: De-integrate follows integrate directly and ends on the first tick that sees a high-to-low comparator transition. The result is the number of de-integrate ticks before that tick.
- R5: Integrator-zero follows de-integrate directly and lasts until a tick sees the comparator high. Auto-zero follows.
- R6: After reset the phase code is 00, valid_n is 1, and result, pol_out and ovr_out are 0.
- R7: While conv_en_n is high, every tick forces auto-zero and restarts its count. After release, a full auto-zero period elapses before integrate.
- R8: valid_n is 0 exactly while the phase is auto-zero, whether that phase was entered normally or forced by the enable input.
- R9: result, pol_out and ovr_out change only at the clock edge where auto-zero is entered. They then take the most recent completed conversion.
- R10: If the de-integrate count reaches all ones (2^CNT_W ticks) with no comparator fall, the block sets ovr_out to 1, saturates result to all ones and moves to integrator-zero. A normal end clears the overrange bit.
- R11: pol_out takes the comparator level sampled on the first de-integrate tick (1 = high).
- R12: The comparator and enable inputs pass through a two-flop synchroniser. A comparator change driven just after a tick edge is acted on at the tick one period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 1 | Zero-crossing comparator from the converter (asynchronous) |
| conv_en_n | input | 1 | Active-low conversion enable; high holds auto-zero (asynchronous) |
| load_val | input | LV_W | Programmed load value that sets auto-zero and integrate length |
| phase_a | output | 1 | Phase code, upper bit |
| phase_b | output | 1 | Phase code, lower bit |
| result | output | CNT_W | Held de-integrate tick count |
| pol_out | output | 1 | Held polarity bit |
| ovr_out | output | 1 | Held overrange bit |
| valid_n | output | 1 | Active-low data-valid, low during auto-zero |

## Verification
Three situations are hard to reach from the ports:
- **Negative polarity with a real count.** This needs the comparator low across the integrate-to-de-integrate boundary, then a rise, then a later fall. The stimulus drops the comparator part-way through integrate, raises it two ticks into de-integrate and drops it three ticks later, so the expected count is 5 with polarity 0.
- **Exact counts and tick alignment.** Every comparator edge is driven on the negative clock edge after a known tick. That tick is located from the edge where the phase code changed to de-integrate, so the expected count follows from the tick arithmetic alone.
- **Overrange within the run budget.** The bench narrows the counter to 12 bits.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
   typedef enum logic [1:0] {
      PH_IZ   = 2'b00,
      PH_AZ   = 2'b01,
      PH_INT  = 2'b10,
      PH_DINT = 2'b11
   } phase_t;
endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   initial begin
      if (STAGES < 2) $error("dslope_sync: STAGES must be at least 2");
      if (W < 1)      $error("dslope_sync: W must be positive");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/dslope_tick_gen.sv
module dslope_tick_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   initial begin
      if (DIV < 1) $error("dslope_tick_gen: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick = rst_n;
   end else begin : g_div
      localparam int DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
         if (!rst_n)              div_q <= '0;
         else if (div_q == LAST)  div_q <= '0;
         else                     div_q <= div_q + 1'b1;
      end
      assign tick = rst_n && (div_q == LAST);
   end
endmodule

// File: rtl/dslope_phase_ctrl.sv
module dslope_phase_ctrl
   import dslope_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int LV_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cmp_s,
   input  logic             hold_s,
   input  logic [LV_W-1:0]  load_val,
   output phase_t           phase,
   output logic             az_entry,
   output logic [CNT_W-1:0] lat_res,
   output logic             lat_pol,
   output logic             lat_ovr
);
   localparam int LOW_W = CNT_W - LV_W;

   initial begin
      if (LOW_W < 1) $error("dslope_phase_ctrl: CNT_W must exceed LV_W");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             cmp_prev_q;
   logic             first_q;
   logic [CNT_W-1:0] preset;
   logic             cnt_full;
   logic             cmp_fall;

   assign preset   = {load_val, {LOW_W{1'b0}}};
   assign cnt_full = &cnt_q;
   assign cmp_fall = cmp_prev_q && !cmp_s;
   assign az_entry = tick && (phase != PH_AZ) &&
                     (hold_s || ((phase == PH_IZ) && cmp_s));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_IZ;
         cnt_q      <= '0;
         cmp_prev_q <= 1'b0;
         first_q    <= 1'b0;
         lat_res    <= '0;
         lat_pol    <= 1'b0;
         lat_ovr    <= 1'b0;
      end else if (tick) begin
         cmp_prev_q <= cmp_s;
         if (hold_s) begin
            phase   <= PH_AZ;
            cnt_q   <= preset;
            first_q <= 1'b0;
         end else begin
            unique case (phase)
               PH_AZ: begin
                  cnt_q <= preset;
                  if (cnt_full) phase <= PH_INT;
                  else          cnt_q <= cnt_q + 1'b1;
               end
               PH_INT: begin
                  if (cnt_full) begin
                     phase   <= PH_DINT;
                     cnt_q   <= '0;
                     first_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               PH_DINT: begin
                  first_q <= 1'b0;
                  if (first_q) lat_pol <= cmp_s;
                  if (cmp_fall) begin
                     phase   <= PH_IZ;
                     lat_res <= cnt_q;
                     lat_ovr <= 1'b0;
                  end else if (cnt_full) begin
                     phase   <= PH_IZ;
                     lat_res <= cnt_q;
                     lat_ovr <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               PH_IZ: begin
                  if (cmp_s) begin
                     phase <= PH_AZ;
                     cnt_q <= preset;
                  end
               end
               default: phase <= PH_IZ;
            endcase
         end
      end
   end
endmodule

// File: rtl/dslope_hold_reg.sv
module dslope_hold_reg #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] res_in,
   input  logic             pol_in,
   input  logic             ovr_in,
   output logic [CNT_W-1:0] res_out,
   output logic             pol_out,
   output logic             ovr_out
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_out <= '0;
         pol_out <= 1'b0;
         ovr_out <= 1'b0;
      end else if (load) begin
         res_out <= res_in;
         pol_out <= pol_in;
         ovr_out <= ovr_in;
      end
   end
endmodule

// File: rtl/dslope_sequencer.sv
module dslope_sequencer
   import dslope_pkg::*;
#(
   parameter int TICK_DIV    = 4,
   parameter int CNT_W       = 16,
   parameter int LV_W        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_in,
   input  logic             conv_en_n,
   input  logic [LV_W-1:0]  load_val,
   output logic             phase_a,
   output logic             phase_b,
   output logic [CNT_W-1:0] result,
   output logic             pol_out,
   output logic             ovr_out,
   output logic             valid_n
);
   initial begin
      if (TICK_DIV < 1)      $error("dslope_sequencer: TICK_DIV must be positive");
      if (LV_W < 1)          $error("dslope_sequencer: LV_W must be positive");
      if (CNT_W <= LV_W)     $error("dslope_sequencer: CNT_W must exceed LV_W");
      if (SYNC_STAGES < 2)   $error("dslope_sequencer: SYNC_STAGES must be at least 2");
   end

   logic             tick;
   logic [1:0]       sync_out;
   logic             cmp_s;
   logic             hold_s;
   phase_t           phase;
   logic             az_entry;
   logic [CNT_W-1:0] lat_res;
   logic             lat_pol;
   logic             lat_ovr;

   dslope_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({conv_en_n, cmp_in}),
      .dout (sync_out)
   );
   assign cmp_s  = sync_out[0];
   assign hold_s = sync_out[1];

   dslope_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   dslope_phase_ctrl #(.CNT_W(CNT_W), .LV_W(LV_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cmp_s   (cmp_s),
      .hold_s  (hold_s),
      .load_val(load_val),
      .phase   (phase),
      .az_entry(az_entry),
      .lat_res (lat_res),
      .lat_pol (lat_pol),
      .lat_ovr (lat_ovr)
   );

   dslope_hold_reg #(.CNT_W(CNT_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (az_entry),
      .res_in (lat_res),
      .pol_in (lat_pol),
      .ovr_in (lat_ovr),
      .res_out(result),
      .pol_out(pol_out),
      .ovr_out(ovr_out)
   );

   assign phase_a = phase[1];
   assign phase_b = phase[0];
   assign valid_n = (phase != PH_AZ);
endmodule

// File: rtl/dslope_sequencer_chk.sv
module dslope_sequencer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             hold_s,
   input logic             phase_a,
   input logic             phase_b,
   input logic             valid_n,
   input logic [CNT_W-1:0] result,
   input logic             pol_out,
   input logic             ovr_out
);
   logic [1:0] ph;
   assign ph = {phase_a, phase_b};

   AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> $stable(ph)); // R2
   AST_AZ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ph) == 2'b01 && ph != 2'b01) |-> ph == 2'b10); // R3
   AST_INT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ph) == 2'b10 && ph != 2'b10) |-> (ph == 2'b11 || ph == 2'b01)); // R1
   AST_DINT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ph) == 2'b11 && ph != 2'b11) |-> (ph == 2'b00 || ph == 2'b01)); // R4
   AST_IZ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ph) == 2'b00 && ph != 2'b00) |-> ph == 2'b01); // R5
   AST_HOLD_FORCES_AZ: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && hold_s) |=> (ph == 2'b01 && !valid_n)); // R7
   AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(valid_n) |-> $stable({ovr_out, pol_out, result})); // R9
   AST_OVR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_out |-> (&result)); // R10
endmodule

bind dslope_sequencer dslope_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick),
   .hold_s (hold_s),
   .phase_a(phase_a),
   .phase_b(phase_b),
   .valid_n(valid_n),
   .result (result),
   .pol_out(pol_out),
   .ovr_out(ovr_out)
);

// File: tb/dslope_sequencer_bench.sv
module dslope_sequencer_bench;
   localparam int BW   = 12;
   localparam int LVW  = 8;
   localparam int DIVN = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cmp_in = 1'b0;
   logic           conv_en_n = 1'b0;
   logic [LVW-1:0] load_val = 8'hFE;
   logic           phase_a, phase_b, pol_out, ovr_out, valid_n;
   logic [BW-1:0]  result;

   int checks = 0;
   int failures = 0;
   logic [BW+1:0] exp_q [$];

   always #2 clk = ~clk;

   dslope_sequencer #(.TICK_DIV(DIVN), .CNT_W(BW), .LV_W(LVW), .SYNC_STAGES(2)) u_dslope_sequencer (
      .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .conv_en_n(conv_en_n),
      .load_val(load_val), .phase_a(phase_a), .phase_b(phase_b),
      .result(result), .pol_out(pol_out), .ovr_out(ovr_out), .valid_n(valid_n)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_range(input string req, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   // driver side of the scoreboard: {ovr, pol, result}
   task automatic push_exp(input logic ovr, input logic pol, input int res);
      exp_q.push_back({ovr, pol, BW'(res)});
   endtask

   task automatic wait_phase(input logic [1:0] ph, output int n);
      n = 0;
      while ({phase_a, phase_b} != ph) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // monitor side: pop on every auto-zero entry
   logic prev_valid = 1'b1;
   always @(negedge clk) begin
      if (rst_n && prev_valid && !valid_n) begin
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R9 actual=unexpected_update expected=no_update");
         end else begin
            logic [BW+1:0] e;
            e = exp_q.pop_front();
            if ({ovr_out, pol_out, result} != e) begin
               failures++;
               $display("FAIL R9/R4/R10/R11 actual=%h expected=%h", {ovr_out, pol_out, result}, e);
            end
         end
      end
      prev_valid <= valid_n;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int n;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6 phase after reset", {phase_a, phase_b}, 0);
      check("R6 valid_n after reset", valid_n, 1);
      check("R6 held outputs after reset", {ovr_out, pol_out, result}, 0);
      repeat (20) @(negedge clk);
      check("R5 waits in IZ while comparator low", {phase_a, phase_b}, 0);

      // first conversion, load value 0xFE: 2*16 ticks = 128 clocks
      push_exp(0, 0, 0);
      cmp_in = 1'b1;
      wait_phase(2'b01, n);
      check("R8 valid_n low in AZ", valid_n, 0);
      wait_phase(2'b10, n);
      check("R3 AZ length in clocks", n, 128);
      check("R8 valid_n high after AZ", valid_n, 1);
      wait_phase(2'b11, n);
      check("R3 R2 INT length in clocks", n, 128);
      repeat (12) @(negedge clk);
      cmp_in = 1'b0;
      push_exp(0, 1, 3);
      wait_phase(2'b00, n);
      check("R4 R12 DINT ends one tick after fall", n, 4);
      repeat (16) @(negedge clk);
      check("R5 IZ holds while comparator low", {phase_a, phase_b}, 0);
      cmp_in = 1'b1;

      // fall right at DINT start: polarity 0, count 0
      wait_phase(2'b11, n);
      cmp_in = 1'b0;
      push_exp(0, 0, 0);
      wait_phase(2'b00, n);
      check("R4 R11 immediate fall", n, 4);
      repeat (6) @(negedge clk);
      cmp_in = 1'b1;

      // negative polarity with a count of 5
      wait_phase(2'b10, n);
      repeat (8) @(negedge clk);
      cmp_in = 1'b0;
      wait_phase(2'b11, n);
      repeat (8) @(negedge clk);
      cmp_in = 1'b1;
      repeat (12) @(negedge clk);
      cmp_in = 1'b0;
      push_exp(0, 0, 5);
      wait_phase(2'b00, n);
      check("R11 R4 low-polarity DINT end", n, 4);
      repeat (4) @(negedge clk);
      cmp_in = 1'b1;

      // overrange: comparator never falls
      push_exp(1, 1, (1 << BW) - 1);
      wait_phase(2'b11, n);
      wait_phase(2'b00, n);
      check("R10 DINT saturates after full count", n, 4 * (1 << BW));

      // forced auto-zero during integrate, new load value 0xFC
      wait_phase(2'b10, n);
      repeat (10) @(negedge clk);
      conv_en_n = 1'b1;
      push_exp(1, 1, (1 << BW) - 1);
      load_val = 8'hFC;
      repeat (12) @(negedge clk);
      check("R7 enable high forces AZ", {phase_a, phase_b}, 1);
      check("R8 valid_n low in forced AZ", valid_n, 0);
      repeat (100) @(negedge clk);
      check("R7 AZ held while enable high", {phase_a, phase_b}, 1);
      conv_en_n = 1'b0;
      wait_phase(2'b10, n);
      check_range("R7 R3 full AZ after release", n, 252, 260);
      wait_phase(2'b11, n);
      check("R3 INT uses new load value", n, 256);
      repeat (28) @(negedge clk);
      cmp_in = 1'b0;
      push_exp(0, 1, 7);
      wait_phase(2'b00, n);
      repeat (8) @(negedge clk);
      cmp_in = 1'b1;
      wait_phase(2'b01, n);
      repeat (4) @(negedge clk);
      check("R9 every expected update seen", exp_q.size(), 0);
      check("R1 phase code AZ", {phase_a, phase_b}, 1);
      finish_run();
   end
endmodule